// File: doc/BRIEF.md
# Configuration Window Decode Checker

This block turns the raw contents of a device's base address registers into decoded address windows. It has six general regions and one expansion ROM region. Each region has a power-of-two size and a kind, I/O or memory, that are fixed at elaboration. Two command enable bits gate each kind. When `eval_req` is pulsed, every region's effective base and mapped flag are computed and registered. The block also marks, for one cycle, each region whose mapping changed since the previous evaluation.

Several base values count as "not mapped" rather than as a real window: a base of zero, a window that wraps, an I/O window that reaches past the 64 KiB port space, a memory window that ends on the all-ones address, and a ROM whose enable bit is clear. The registered windows also drive a set of hit comparators for an incoming access address and kind, so a decoder next to this block can select the target region.

Top module: `region_map_eval`

## Requirements
- R1: Region i (0..5) is read from `bar_raw[32*i +: 32]` and the ROM region from `rom_raw`. Output slot 6 is the ROM. The effective base is the raw value ANDed with ~(size-1). It appears on `region_base` with `region_valid` set when the region maps. An unmapped region shows base 0 and valid 0.
- R2: An I/O region maps only while `cmd_enables[0]` is 1. A memory region, including the ROM, maps only while `cmd_enables[1]` is 1.
- R3: A region whose effective base is zero is unmapped.
- R4: An I/O region whose last address (base + size - 1) is 0x10000 or above is unmapped.
- R5: A memory region whose last address equals 0xFFFFFFFF, or whose last address does not exceed its base, is unmapped.
- R6: The ROM region is always memory. It maps only when bit 0 of `rom_raw` is 1, and that bit never appears in its base.
- R7: A region configured with size zero never maps, never hits and never pulses its change flag.
- R8: Outputs change only at the clock edge where `eval_req` is 1, and the new values are visible in the following cycle. Raw inputs and enables that change without `eval_req` leave the outputs unchanged.
- R9: `region_changed[i]` is 1 for exactly the cycle after an evaluation in which region i's mapped flag or base differs from its previous registered value. It is 0 otherwise.
- R10: `region_hit[i]` is 1 when region i is mapped, `acc_is_io` equals the region's kind (1 = I/O), and base <= `acc_addr` <= base + size - 1. This output is combinational from the registered state.
- R11: After reset, all mapped flags, bases and change flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_req | input | 1 | Capture decode of the current inputs |
| cmd_enables | input | 2 | Bit 0 I/O enable, bit 1 memory enable |
| bar_raw | input | 192 | Raw values of regions 0..5, region i at bits 32*i |
| rom_raw | input | 32 | Raw ROM region value, bit 0 is its enable |
| acc_addr | input | 32 | Access address for hit compare |
| acc_is_io | input | 1 | Access kind, 1 = I/O, 0 = memory |
| region_valid | output | 7 | Mapped flag per region, slot 6 = ROM |
| region_base | output | 224 | Effective base per region, slot i at bits 32*i |
| region_changed | output | 7 | One-cycle mapping change flag per region |
| region_hit | output | 7 | Access falls inside a mapped region of matching kind |

## Verification
A corrupted stored base or mapped flag shows on `region_base` and `region_valid` in the cycle after the evaluation that wrote it. It also shifts `region_hit` immediately, because the hit comparators read the stored window directly. A wrong previous-value record shows one cycle after the next evaluation, as a missing or extra `region_changed` pulse. The directed tests therefore probe each unmapping rule on both sides of its boundary, repeat an evaluation with identical inputs, and move raw values without an evaluation.

// File: rtl/rme_pkg.sv
package rme_pkg;
   // Bit positions inside the command enable input.
   localparam int unsigned CMD_IO_BIT  = 0;
   localparam int unsigned CMD_MEM_BIT = 1;

   typedef enum logic {
      KIND_MEM = 1'b0,
      KIND_IO  = 1'b1
   } region_kind_e;
endpackage

// File: rtl/rme_region_decode.sv
// Combinational decode of one region: masked base, last address, mapped flag.
module rme_region_decode #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned IO_SPACE_W = 16,
   parameter int unsigned SIZE_LOG2  = 8,
   parameter bit          IS_IO      = 1'b0,
   parameter bit          IS_ROM     = 1'b0
) (
   input  logic [ADDR_W-1:0] raw,
   input  logic              io_en,
   input  logic              mem_en,
   output logic              map_ok,
   output logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] last
);
   localparam logic [ADDR_W-1:0] ONE     = {{(ADDR_W-1){1'b0}}, 1'b1};
   localparam logic [ADDR_W-1:0] SPAN_M1 = (ONE << SIZE_LOG2) - ONE;
   localparam logic [ADDR_W-1:0] MASK    = ~SPAN_M1;

   if (SIZE_LOG2 == 0) begin : g_empty
      logic unused_in;
      assign unused_in = ^{raw, io_en, mem_en};
      assign map_ok = 1'b0;
      assign base   = '0;
      assign last   = '0;
   end else begin : g_sized
      logic [ADDR_W-1:0] masked, top_addr;
      logic              shape_ok, fits;

      always_comb begin
         masked   = raw & MASK;
         top_addr = masked + SPAN_M1;
         shape_ok = (masked != '0) && (top_addr > masked);
      end

      if (IS_IO) begin : g_io
         logic unused_in;
         assign unused_in = mem_en;
         assign fits = io_en && shape_ok && ((top_addr >> IO_SPACE_W) == '0);
      end else begin : g_mem
         logic unused_in;
         logic rom_gate;
         assign unused_in = io_en;
         assign rom_gate  = IS_ROM ? raw[0] : 1'b1;
         assign fits = mem_en && rom_gate && shape_ok && (top_addr != '1);
      end

      assign map_ok = fits;
      assign base   = fits ? masked   : '0;
      assign last   = fits ? top_addr : '0;
   end
endmodule

// File: rtl/rme_region_track.sv
// Holds one region's evaluated window and flags changes between evaluations.
module rme_region_track #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eval,
   input  logic              in_ok,
   input  logic [ADDR_W-1:0] in_base,
   input  logic [ADDR_W-1:0] in_last,
   output logic              ok_q,
   output logic [ADDR_W-1:0] base_q,
   output logic [ADDR_W-1:0] last_q,
   output logic              changed_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ok_q      <= 1'b0;
         base_q    <= '0;
         last_q    <= '0;
         changed_q <= 1'b0;
      end else begin
         changed_q <= eval && ((in_ok != ok_q) || (in_base != base_q));
         if (eval) begin
            ok_q   <= in_ok;
            base_q <= in_base;
            last_q <= in_last;
         end
      end
   end

   // R8: without an evaluation the stored window holds.
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !eval |=> ($stable(base_q) && $stable(ok_q)));
   // R9: a change flag never survives a cycle without an evaluation.
   p_pulse_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (changed_q && !eval) |=> !changed_q);
   // R3: a mapped window never starts at zero.
   p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ok_q |-> (base_q != '0));
endmodule

// File: rtl/region_map_eval.sv
module region_map_eval #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned IO_SPACE_W = 16,
   parameter int unsigned NUM_BARS   = 6,
   parameter int unsigned REGION_LOG2 [NUM_BARS+1] = '{8, 4, 12, 0, 5, 16, 11},
   parameter logic [NUM_BARS-1:0] BAR_IS_IO = 6'b010010
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           eval_req,
   input  logic [1:0]                     cmd_enables,
   input  logic [NUM_BARS*ADDR_W-1:0]     bar_raw,
   input  logic [ADDR_W-1:0]              rom_raw,
   input  logic [ADDR_W-1:0]              acc_addr,
   input  logic                           acc_is_io,
   output logic [NUM_BARS:0]              region_valid,
   output logic [(NUM_BARS+1)*ADDR_W-1:0] region_base,
   output logic [NUM_BARS:0]              region_changed,
   output logic [NUM_BARS:0]              region_hit
);
   import rme_pkg::*;

   localparam int unsigned NREG    = NUM_BARS + 1;
   localparam int unsigned ROM_IDX = NUM_BARS;

   if (NUM_BARS < 1) begin : g_bad_count
      $error("NUM_BARS must be at least 1");
   end
   if (IO_SPACE_W >= ADDR_W) begin : g_bad_io_w
      $error("IO_SPACE_W must be narrower than ADDR_W");
   end

   logic io_en, mem_en;
   assign io_en  = cmd_enables[CMD_IO_BIT];
   assign mem_en = cmd_enables[CMD_MEM_BIT];

   for (genvar i = 0; i < NREG; i++) begin : g_region
      localparam bit IS_ROM = (i == ROM_IDX);
      localparam bit IS_IO  = IS_ROM ? 1'b0 : BAR_IS_IO[i];
      localparam region_kind_e KIND = IS_IO ? KIND_IO : KIND_MEM;

      if (REGION_LOG2[i] >= ADDR_W) begin : g_bad_size
         $error("region size exceeds address width");
      end
      if (IS_IO && REGION_LOG2[i] > IO_SPACE_W) begin : g_bad_io_size
         $error("I/O region larger than the port space");
      end

      logic [ADDR_W-1:0] raw, d_base, d_last, last_q, base_q;
      logic              d_ok;

      if (IS_ROM) begin : g_rom_src
         assign raw = rom_raw;
      end else begin : g_bar_src
         assign raw = bar_raw[i*ADDR_W +: ADDR_W];
      end

      rme_region_decode #(
         .ADDR_W     (ADDR_W),
         .IO_SPACE_W (IO_SPACE_W),
         .SIZE_LOG2  (REGION_LOG2[i]),
         .IS_IO      (IS_IO),
         .IS_ROM     (IS_ROM)
      ) u_dec (
         .raw    (raw),
         .io_en  (io_en),
         .mem_en (mem_en),
         .map_ok (d_ok),
         .base   (d_base),
         .last   (d_last)
      );

      rme_region_track #(
         .ADDR_W (ADDR_W)
      ) u_trk (
         .clk       (clk),
         .rst_n     (rst_n),
         .eval      (eval_req),
         .in_ok     (d_ok),
         .in_base   (d_base),
         .in_last   (d_last),
         .ok_q      (region_valid[i]),
         .base_q    (base_q),
         .last_q    (last_q),
         .changed_q (region_changed[i])
      );

      assign region_base[i*ADDR_W +: ADDR_W] = base_q;
      assign region_hit[i] = region_valid[i]
                           && (region_kind_e'(acc_is_io) == KIND)
                           && (acc_addr >= base_q)
                           && (acc_addr <= last_q);

      if (IS_IO) begin : g_io_chk
         // R2: I/O enable low at evaluation leaves the region unmapped.
         p_io_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (eval_req && !io_en) |=> !region_valid[i]);
         // R4: a mapped I/O window ends inside the port space.
         p_io_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
            region_valid[i] |-> ((last_q >> IO_SPACE_W) == '0));
      end else begin : g_mem_chk
         // R2: memory enable low at evaluation leaves the region unmapped.
         p_mem_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (eval_req && !mem_en) |=> !region_valid[i]);
         // R5: a mapped memory window never ends on the all-ones address.
         p_mem_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
            region_valid[i] |-> (last_q != '1));
      end

      if (IS_ROM) begin : g_rom_chk
         // R6: ROM enable bit clear at evaluation leaves the ROM unmapped.
         p_rom_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (eval_req && !rom_raw[0]) |=> !region_valid[i]);
      end
   end
endmodule

// File: tb/tb_region_map_eval.sv
module tb_region_map_eval;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 6;
   localparam int NR = 7;
   localparam int L2 [NR] = '{8, 4, 12, 0, 5, 16, 11};
   localparam logic [NR-1:0] KIND_IO = 7'b0010010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic eval_req = 1'b0;
   logic [1:0] cmd_enables = 2'b00;
   logic [NB*32-1:0] bar_raw;
   logic [31:0] rom_raw = '0;
   logic [31:0] acc_addr = '0;
   logic acc_is_io = 1'b0;
   logic [NR-1:0] region_valid, region_changed, region_hit;
   logic [NR*32-1:0] region_base;

   logic [31:0] bars [NB];
   logic        pv [NR];
   logic [31:0] pb [NR];
   int checks = 0;
   int failures = 0;
   bit done = 0;

   region_map_eval dut (
      .clk(clk), .rst_n(rst_n), .eval_req(eval_req), .cmd_enables(cmd_enables),
      .bar_raw(bar_raw), .rom_raw(rom_raw), .acc_addr(acc_addr), .acc_is_io(acc_is_io),
      .region_valid(region_valid), .region_base(region_base),
      .region_changed(region_changed), .region_hit(region_hit)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int i = 0; i < NB; i++) bar_raw[i*32 +: 32] = bars[i];
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Model built from the requirements: {valid, base}.
   function automatic logic [32:0] model(int idx);
      logic [31:0] raw;
      longint unsigned sz, b, l;
      logic ok;
      raw = (idx == NB) ? rom_raw : bars[idx];
      if (L2[idx] == 0) return '0;
      sz = 64'd1 << L2[idx];
      b  = {32'd0, raw} & ~(sz - 1);
      l  = b + sz - 1;
      ok = (b != 0) && (l <= 64'hFFFF_FFFF) && (l[31:0] > b[31:0]);
      if (KIND_IO[idx]) ok = ok && cmd_enables[0] && (l < 64'h1_0000);
      else begin
         ok = ok && cmd_enables[1] && (l[31:0] != 32'hFFFF_FFFF);
         if (idx == NB) ok = ok && raw[0];
      end
      return ok ? {1'b1, b[31:0]} : 33'd0;
   endfunction

   // Evaluate, then check windows, change flags, and the flag clearing.
   task automatic do_eval(string req);
      logic [32:0] e [NR];
      for (int i = 0; i < NR; i++) e[i] = model(i);
      @(negedge clk); eval_req = 1'b1;
      @(negedge clk); eval_req = 1'b0;
      for (int i = 0; i < NR; i++) begin
         chk({req, " valid"}, 32'(region_valid[i]), 32'(e[i][32]));
         chk({req, " base"}, region_base[i*32 +: 32], e[i][31:0]);
         chk({req, " R9 changed"}, 32'(region_changed[i]),
             32'((e[i][32] != pv[i]) || (e[i][31:0] != pb[i])));
         pv[i] = e[i][32];
         pb[i] = e[i][31:0];
      end
      @(negedge clk);
      chk({req, " R9 pulse width"}, 32'(region_changed), 32'd0);
   endtask

   task automatic hit_at(string req, logic [31:0] a, logic io, logic [NR-1:0] exp);
      acc_addr = a; acc_is_io = io;
      #1;
      chk(req, 32'(region_hit), 32'(exp));
   endtask

   task automatic t_reset();
      chk("R11 valid", 32'(region_valid), 32'd0);
      chk("R11 changed", 32'(region_changed), 32'd0);
      chk("R11 base0", region_base[31:0], 32'd0);
      chk("R11 base rom", region_base[6*32 +: 32], 32'd0);
   endtask

   task automatic t_mem_basic();
      cmd_enables = 2'b10;
      bars[0] = 32'h1234_5678; bars[2] = 32'h8000_0ABC;
      do_eval("R1");
      chk("R1 base0 value", region_base[31:0], 32'h1234_5600);
      chk("R1 base2 value", region_base[64 +: 32], 32'h8000_0000);
   endtask

   task automatic t_cmd_gate();
      bars[1] = 32'h0000_1234; bars[4] = 32'h0000_2040;
      do_eval("R2 mem only");
      chk("R2 io off", 32'(region_valid[1]), 32'd0);
      cmd_enables = 2'b01;
      do_eval("R2 io only");
      chk("R2 io on", 32'(region_valid[1]), 32'd1);
      chk("R2 mem off", 32'(region_valid[0]), 32'd0);
      cmd_enables = 2'b11;
      do_eval("R2 both");
      chk("R2 io base", region_base[32 +: 32], 32'h0000_1230);
   endtask

   task automatic t_zero();
      bars[0] = 32'h0000_00FF;
      do_eval("R3");
      chk("R3 zero base unmapped", 32'(region_valid[0]), 32'd0);
      bars[0] = 32'h1234_5678;
      do_eval("R3 restore");
   endtask

   task automatic t_io_window();
      bars[1] = 32'h0000_FFF7;
      do_eval("R4 edge");
      chk("R4 last 0xFFFF maps", 32'(region_valid[1]), 32'd1);
      bars[1] = 32'h0001_0005;
      do_eval("R4 over");
      chk("R4 beyond port space", 32'(region_valid[1]), 32'd0);
      bars[1] = 32'h0000_FFF7;
      do_eval("R4 back");
   endtask

   task automatic t_mem_top();
      bars[5] = 32'hFFFF_1234;
      do_eval("R5 top");
      chk("R5 all-ones end", 32'(region_valid[5]), 32'd0);
      bars[5] = 32'hFFFE_0000;
      do_eval("R5 below");
      chk("R5 below top maps", 32'(region_valid[5]), 32'd1);
   endtask

   task automatic t_rom();
      rom_raw = 32'h000C_0000;
      do_eval("R6 off");
      chk("R6 enable clear", 32'(region_valid[6]), 32'd0);
      rom_raw = 32'h000C_07FF;
      do_eval("R6 on");
      chk("R6 base drops enable", region_base[6*32 +: 32], 32'h000C_0000);
   endtask

   task automatic t_empty();
      bars[3] = 32'h4000_0000;
      do_eval("R7");
      chk("R7 empty unmapped", 32'(region_valid[3]), 32'd0);
      hit_at("R7 empty no hit", 32'h4000_0000, 1'b0, 7'd0);
   endtask

   task automatic t_hold();
      bars[0] = 32'h5555_0000; cmd_enables = 2'b00; rom_raw = 32'h0;
      repeat (3) @(negedge clk);
      chk("R8 base held", region_base[31:0], 32'h1234_5600);
      chk("R8 valid held", 32'(region_valid), 32'(7'b1110111));
      chk("R8 no change flag", 32'(region_changed), 32'd0);
      bars[0] = 32'h1234_5678; cmd_enables = 2'b11; rom_raw = 32'h000C_07FF;
      do_eval("R9 identical re-eval");
   endtask

   task automatic t_hit();
      hit_at("R10 first byte", 32'h1234_5600, 1'b0, 7'b0000001);
      hit_at("R10 last byte", 32'h1234_56FF, 1'b0, 7'b0000001);
      hit_at("R10 one past", 32'h1234_5700, 1'b0, 7'd0);
      hit_at("R10 one before", 32'h1234_55FF, 1'b0, 7'd0);
      hit_at("R10 wrong kind", 32'h1234_5600, 1'b1, 7'd0);
      hit_at("R10 io last", 32'h0000_FFFF, 1'b1, 7'b0000010);
      hit_at("R10 io as mem", 32'h0000_FFFF, 1'b0, 7'd0);
      hit_at("R10 rom", 32'h000C_0400, 1'b0, 7'b1000000);
   endtask

   initial begin
      for (int i = 0; i < NB; i++) bars[i] = '0;
      for (int i = 0; i < NR; i++) begin pv[i] = 1'b0; pb[i] = '0; end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mem_basic();
      t_cmd_gate();
      t_zero();
      t_io_window();
      t_mem_top();
      t_rom();
      t_empty();
      t_hold();
      t_hit();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule